// File: doc/BRIEF.md
# Multiplexed Processor Bus Cycle Sequencer

This block turns single transfer requests from a processor core into bus cycles on a multiplexed address/data bus. Each cycle steps through the states T1, T2, T3, zero or more wait states (Tw) and T4. The block drives an address latch enable pulse, active-low read, write and interrupt-acknowledge strobes, a byte-high enable, the upper address lines and a 3-bit status code. It returns the captured read data and a one-cycle completion pulse.

The core offers a request as a kind (read, write or interrupt acknowledge), a 20-bit address, a word/byte flag and write data. It holds the request until the block takes it. A byte moves on the lane its address selects. A word at an odd address is split into two byte cycles. A wait state is inserted for every clock edge at which the ready input is found low at the end of T3 or of a wait state. A reset must stay low for several consecutive cycles to arm the block. A shorter pulse leaves it idle and refusing work until a full reset comes.

Top module: `bus_cycle_seq`

## Requirements
- R1: A taken request puts the sequencer in T1 on the next clock edge. T2, T3, any wait states and T4 then follow, one per cycle. After the final T4 the sequencer returns to idle unless it takes another request in that T4.
- R2: The status code is 3'b101 for a read, 3'b110 for a write, 3'b000 for an interrupt acknowledge and 3'b111 (passive) otherwise.
  - It shows the cycle's code in T1 and T2, and in T3 or Tw while ready is low.
  - It is passive in the T3 or Tw where ready is high, in T4 and in idle.
  - Exception: a T4 that is followed at once by another cycle shows the code of that next cycle.
- R3: `ale` is high in T1 only. In T1 of a read or write, `ad_out` carries address bits 15:0 and `addr_hi` carries bits 19:16. In T1 of an interrupt acknowledge, both are zero.
- R4: `rd_n`, `wr_n` and `inta_n` are low in T2, T3 and Tw of read, write and acknowledge cycles respectively. They are high otherwise, and never more than one is low at a time.
- R5: During T2, T3, Tw and T4 of a write, `ad_out` carries the write data on the lane given in R7.
- R6: Ready is sampled at the clock edge that ends T3 or Tw. Low gives a Tw next; high gives T4 next.
- R7: Lane selection uses `bhe_n` and A0 (`ad_out[0]` in T1). Write data bits 7:0 go to the lane that is selected.

  | Transfer | `bhe_n` | A0 | Lanes used |
  |---|---|---|---|
  | Aligned word | 0 | 0 | both lanes |
  | Byte at even address | 1 | 0 | `ad[7:0]` |
  | Byte at odd address | 0 | 1 | `ad[15:8]` |
  | Interrupt acknowledge | 1 | — | — |
- R8: A word at an odd address runs as two cycles.
  - First, a byte cycle at the address moves data bits 7:0 on the upper lane.
  - Then, a byte cycle at address+1 moves bits 15:8 on the lower lane.
  - `done` is raised only in the T4 of the second cycle.
- R9: `rdata` is loaded at the edge ending the last T3/Tw of a read or acknowledge. An aligned word takes all of `ad_in`. A byte takes its lane into bits 7:0, with zero above. An acknowledge takes `ad_in[7:0]`. A split word joins the two bytes. `done` is high for exactly the final T4.
- R10: While `rst_n` is low, the sequencer goes to idle with all strobes high, `ale` low and passive status. It accepts requests only after a reset that lasted at least four consecutive cycles. After a shorter pulse, `req_take` stays low.
- R11: A request with kind code 2'b11 is never taken and starts no cycle.
- R12: `req_take` is high, in the same cycle, only when a valid request is offered in idle or in a final T4. A request offered during T1 to T3/Tw is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core offers a request |
| req_kind | input | 2 | 0 read, 1 write, 2 interrupt acknowledge, 3 not accepted |
| req_addr | input | 20 | Byte address |
| req_word | input | 1 | 1 word, 0 byte |
| req_wdata | input | 16 | Write data |
| req_take | output | 1 | Request taken this cycle |
| ready | input | 1 | Slave ready, low inserts wait states |
| ad_in | input | 16 | Data returned on the multiplexed bus |
| ale | output | 1 | Address latch enable |
| ad_out | output | 16 | Multiplexed address/data driven |
| addr_hi | output | 4 | Address bits 19:16 in T1 |
| bhe_n | output | 1 | Byte-high enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt-acknowledge strobe, active low |
| stat | output | 3 | Cycle status code |
| rdata | output | 16 | Captured read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
Counting from the cycle in which `req_take` is high, T1 lies one edge later, T2 two edges later and T3 three edges later. T4, with `done` and the new `rdata`, lies four edges plus the number of low-ready edges later. A split word adds a second cycle that follows at once.

The bench drives inputs on the falling edge. It checks every output 1 ns later in each state of each cycle, and sets ready and `ad_in` as it enters T3 and each wait state. That way, every value is compared in the very cycle the requirements place it, not merely at some later point.

// File: rtl/bus_seq_pkg.sv
// Shared types for the bus cycle sequencer.
// Assumes a 3-bit status code with all ones meaning passive.
package bus_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5
    } bstate_t;

    typedef enum logic [1:0] {
        K_READ  = 2'd0,
        K_WRITE = 2'd1,
        K_INTA  = 2'd2,
        K_NONE  = 2'd3
    } kind_t;

    localparam logic [2:0] STAT_READ    = 3'b101;
    localparam logic [2:0] STAT_WRITE   = 3'b110;
    localparam logic [2:0] STAT_INTA    = 3'b000;
    localparam logic [2:0] STAT_PASSIVE = 3'b111;

    function automatic logic [2:0] stat_code(input kind_t k);
        case (k)
            K_READ:  stat_code = STAT_READ;
            K_WRITE: stat_code = STAT_WRITE;
            K_INTA:  stat_code = STAT_INTA;
            default: stat_code = STAT_PASSIVE;
        endcase
    endfunction

endpackage

// File: rtl/bus_rst_qual.sv
// Reset qualifier: arms the sequencer only after rst_n has been low for
// RST_HOLD consecutive clock edges. A shorter pulse disarms it.
// Assumes RST_HOLD >= 2.
module bus_rst_qual #(
    parameter int RST_HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic armed
);
    localparam int HIST_W = RST_HOLD - 1;

    logic [HIST_W-1:0] low_hist;

    // Purpose: remember how many of the last edges saw reset low.
    always_ff @(posedge clk) begin
        low_hist <= {low_hist[HIST_W-2:0], ~rst_n};
    end

    // Purpose: arm after a long enough reset; a short reset leaves it disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= &low_hist;
        end
    end

endmodule

// File: rtl/bus_seq_fsm.sv
// Bus cycle state machine: T1, T2, T3, Tw*, T4. Takes requests in idle or
// in a final T4, and splits odd-address words into two byte cycles.
// Assumes the request is held stable until req_take is seen.
module bus_seq_fsm
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ready,
    output logic              req_take,
    output bstate_t           state,
    output kind_t             kind,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              word,
    output logic              split,
    output logic              phase,
    output logic [DATA_W-1:0] wdata,
    output logic              cap,
    output logic              done,
    output logic              next_start,
    output kind_t             next_kind
);
    bstate_t state_d;
    logic    last_phase;
    logic    open_slot;
    logic    [ADDR_W-1:0] addr_q;

    // Purpose: decode the slot in which a new request may be taken.
    always_comb begin
        last_phase = !split || phase;
        open_slot  = (state == ST_IDLE) || ((state == ST_T4) && last_phase);
        req_take   = armed && req_valid && (req_kind != K_NONE) && open_slot;
        cap        = ((state == ST_T3) || (state == ST_TW)) && ready;
        done       = (state == ST_T4) && last_phase;
        next_start = (state == ST_T4) && (req_take || !last_phase);
        next_kind  = req_take ? kind_t'(req_kind) : kind;
        cur_addr   = addr_q + ADDR_W'(phase);
    end

    // Purpose: next-state selection for the bus cycle.
    always_comb begin
        state_d = state;
        case (state)
            ST_IDLE: state_d = req_take ? ST_T1 : ST_IDLE;
            ST_T1:   state_d = ST_T2;
            ST_T2:   state_d = ST_T3;
            ST_T3,
            ST_TW:   state_d = ready ? ST_T4 : ST_TW;
            ST_T4: begin
                if (!last_phase || req_take) state_d = ST_T1;
                else                         state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Purpose: state register and request latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            kind   <= K_READ;
            addr_q <= '0;
            word   <= 1'b0;
            split  <= 1'b0;
            phase  <= 1'b0;
            wdata  <= '0;
        end else begin
            state <= state_d;
            if (req_take) begin
                kind   <= kind_t'(req_kind);
                addr_q <= req_addr;
                word   <= req_word;
                wdata  <= req_wdata;
                split  <= req_word && req_addr[0] && (req_kind != K_INTA);
                phase  <= 1'b0;
            end else if ((state == ST_T4) && !last_phase) begin
                phase <= 1'b1;
            end
        end
    end

    // R1: fixed order of the early states.
    a_r1_t1_to_t2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_T1 |=> state == ST_T2);
    a_r1_t2_to_t3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_T2 |=> state == ST_T3);
    // R6: low ready inserts a wait state, high ready ends it.
    a_r6_wait: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_T3) || (state == ST_TW)) && !ready |=> state == ST_TW);
    a_r6_end: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_T3) || (state == ST_TW)) && ready |=> state == ST_T4);
    // R8: first half of a split word is followed directly by the second.
    a_r8_second_half: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T4) && split && !phase |=> (state == ST_T1) && phase);
    // R10: a disarmed sequencer stays idle.
    a_r10_disarmed_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> state == ST_IDLE);

endmodule

// File: rtl/bus_lane_sel.sv
// Byte-lane selection: byte-high enable, write lane placement and read
// capture lanes for aligned words, bytes, split word halves and acknowledges.
// Assumes DATA_W is two bytes wide.
module bus_lane_sel
    import bus_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  kind_t               kind,
    input  logic                word,
    input  logic                split,
    input  logic                phase,
    input  logic                addr0,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W-1:0]   ad_in,
    output logic                bhe_n,
    output logic [DATA_W-1:0]   wr_lane,
    output logic                cap_en,
    output logic                cap_lo_en,
    output logic [DATA_W/2-1:0] cap_lo,
    output logic [DATA_W/2-1:0] cap_hi
);
    localparam int BYTE_W = DATA_W / 2;

    logic [BYTE_W-1:0] w_lo, w_hi, in_lo, in_hi;

    // Purpose: choose lanes for the current transfer.
    always_comb begin
        w_lo      = wdata[BYTE_W-1:0];
        w_hi      = wdata[DATA_W-1:BYTE_W];
        in_lo     = ad_in[BYTE_W-1:0];
        in_hi     = ad_in[DATA_W-1:BYTE_W];
        cap_en    = (kind != K_WRITE);
        cap_lo_en = 1'b1;
        cap_hi    = '0;
        cap_lo    = in_lo;
        bhe_n     = 1'b1;
        wr_lane   = '0;
        if (kind == K_INTA) begin
            bhe_n = 1'b1;
        end else if (word && !split) begin
            bhe_n   = 1'b0;
            wr_lane = wdata;
            cap_hi  = in_hi;
        end else if (split && !phase) begin
            bhe_n   = 1'b0;
            wr_lane = {w_lo, {BYTE_W{1'b0}}};
            cap_lo  = in_hi;
        end else if (split) begin
            bhe_n     = 1'b1;
            wr_lane   = {{BYTE_W{1'b0}}, w_hi};
            cap_lo_en = 1'b0;
            cap_hi    = in_lo;
        end else if (addr0) begin
            bhe_n   = 1'b0;
            wr_lane = {w_lo, {BYTE_W{1'b0}}};
            cap_lo  = in_hi;
        end else begin
            bhe_n   = 1'b1;
            wr_lane = {{BYTE_W{1'b0}}, w_lo};
        end
    end

endmodule

// File: rtl/bus_pin_drv.sv
// Pin driver: ALE, strobes, status code and the multiplexed address/data
// output, all decoded from the sequencer state.
// Assumes ADDR_W = DATA_W + HI_W.
module bus_pin_drv
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int HI_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bstate_t           state,
    input  kind_t             kind,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [DATA_W-1:0] wr_lane,
    input  logic              ready,
    input  logic              next_start,
    input  kind_t             next_kind,
    output logic              ale,
    output logic [DATA_W-1:0] ad_out,
    output logic [HI_W-1:0]   addr_hi,
    output logic              rd_n,
    output logic              wr_n,
    output logic              inta_n,
    output logic [2:0]        stat
);
    logic strobe_win;
    logic stat_on;
    logic addr_phase;

    // Purpose: decode strobes, status and bus contents per state.
    always_comb begin
        strobe_win = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);
        addr_phase = (state == ST_T1) && (kind != K_INTA);
        ale        = (state == ST_T1);
        rd_n       = !(strobe_win && (kind == K_READ));
        wr_n       = !(strobe_win && (kind == K_WRITE));
        inta_n     = !(strobe_win && (kind == K_INTA));
        stat_on    = (state == ST_T1) || (state == ST_T2) ||
                     (((state == ST_T3) || (state == ST_TW)) && !ready);
        if (next_start)   stat = stat_code(next_kind);
        else if (stat_on) stat = stat_code(kind);
        else              stat = STAT_PASSIVE;
        addr_hi = addr_phase ? cur_addr[ADDR_W-1 -: HI_W] : '0;
        if (addr_phase)
            ad_out = cur_addr[DATA_W-1:0];
        else if ((kind == K_WRITE) && (strobe_win || (state == ST_T4)))
            ad_out = wr_lane;
        else
            ad_out = '0;
    end

    // R3: the latch enable is a single-cycle pulse.
    a_r3_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);
    // R4: no two strobes at once.
    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~rd_n, ~wr_n, ~inta_n}) <= 1);
    // R2: a cycle start always carries an active status code.
    a_r2_start_active: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |-> stat != STAT_PASSIVE);

endmodule

// File: rtl/bus_cycle_seq.sv
// Top of the multiplexed bus cycle sequencer. Ties together the reset
// qualifier, state machine, lane selector and pin driver, and holds rdata.
// Assumes ADDR_W = DATA_W + HI_W and a two-byte data bus.
module bus_cycle_seq
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 16,
    parameter int HI_W     = 4,
    parameter int RST_HOLD = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_take,
    input  logic              ready,
    input  logic [DATA_W-1:0] ad_in,
    output logic              ale,
    output logic [DATA_W-1:0] ad_out,
    output logic [HI_W-1:0]   addr_hi,
    output logic              bhe_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              inta_n,
    output logic [2:0]        stat,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);
    localparam int BYTE_W = DATA_W / 2;

    logic              armed;
    bstate_t           state;
    kind_t             kind, next_kind;
    logic [ADDR_W-1:0] cur_addr;
    logic              word, split, phase, cap, next_start;
    logic [DATA_W-1:0] wdata, wr_lane;
    logic              cap_en, cap_lo_en;
    logic [BYTE_W-1:0] cap_lo, cap_hi;

    bus_rst_qual #(.RST_HOLD(RST_HOLD)) u_rst (
        .clk(clk), .rst_n(rst_n), .armed(armed)
    );

    bus_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .armed(armed),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_word(req_word), .req_wdata(req_wdata), .ready(ready),
        .req_take(req_take), .state(state), .kind(kind), .cur_addr(cur_addr),
        .word(word), .split(split), .phase(phase), .wdata(wdata),
        .cap(cap), .done(done), .next_start(next_start), .next_kind(next_kind)
    );

    bus_lane_sel #(.DATA_W(DATA_W)) u_lane (
        .kind(kind), .word(word), .split(split), .phase(phase),
        .addr0(cur_addr[0]), .wdata(wdata), .ad_in(ad_in),
        .bhe_n(bhe_n), .wr_lane(wr_lane), .cap_en(cap_en),
        .cap_lo_en(cap_lo_en), .cap_lo(cap_lo), .cap_hi(cap_hi)
    );

    bus_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HI_W(HI_W)) u_pins (
        .clk(clk), .rst_n(rst_n), .state(state), .kind(kind),
        .cur_addr(cur_addr), .wr_lane(wr_lane), .ready(ready),
        .next_start(next_start), .next_kind(next_kind),
        .ale(ale), .ad_out(ad_out), .addr_hi(addr_hi),
        .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .stat(stat)
    );

    // Purpose: load read data at the edge that ends the last T3/Tw.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (cap && cap_en) begin
            if (cap_lo_en) rdata[BYTE_W-1:0] <= cap_lo;
            rdata[DATA_W-1:BYTE_W] <= cap_hi;
        end
    end

    // R9: completion always follows a capture edge.
    a_r9_done_after_cap: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cap));
    // R9: done lasts a single cycle.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/bus_cycle_seq_test.sv
module bus_cycle_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [19:0] req_addr = '0;
    logic        req_word = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        req_take;
    logic        ready = 1'b1;
    logic [15:0] ad_in = '0;
    logic        ale, bhe_n, rd_n, wr_n, inta_n, done;
    logic [15:0] ad_out, rdata;
    logic [3:0]  addr_hi;
    logic [2:0]  stat;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    bus_cycle_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_word(req_word), .req_wdata(req_wdata),
        .req_take(req_take), .ready(ready), .ad_in(ad_in), .ale(ale),
        .ad_out(ad_out), .addr_hi(addr_hi), .bhe_n(bhe_n), .rd_n(rd_n),
        .wr_n(wr_n), .inta_n(inta_n), .stat(stat), .rdata(rdata), .done(done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] code_of(input int k);
        case (k)
            0: return 3'b101;
            1: return 3'b110;
            2: return 3'b000;
            default: return 3'b111;
        endcase
    endfunction

    function automatic logic is_split(input int k, input logic [19:0] a, input logic w);
        return w && a[0] && (k != 2);
    endfunction

    function automatic logic exp_bhe(input int k, input logic [19:0] a, input logic w, input int ph);
        if (k == 2) return 1'b1;
        if (w && !a[0]) return 1'b0;
        if (is_split(k, a, w)) return (ph == 0) ? 1'b0 : 1'b1;
        return a[0] ? 1'b0 : 1'b1;
    endfunction

    function automatic logic [15:0] exp_lane(input logic [19:0] a, input logic w, input int ph, input logic [15:0] d);
        if (w && !a[0]) return d;
        if (w) return (ph == 0) ? {d[7:0], 8'h00} : {8'h00, d[15:8]};
        return a[0] ? {d[7:0], 8'h00} : {8'h00, d[7:0]};
    endfunction

    function automatic logic [15:0] exp_rd(input int k, input logic [19:0] a, input logic w,
                                           input logic [15:0] d0, input logic [15:0] d1);
        if (k == 2) return {8'h00, d0[7:0]};
        if (w && !a[0]) return d0;
        if (w) return {d1[7:0], d0[15:8]};
        return a[0] ? {8'h00, d0[15:8]} : {8'h00, d0[7:0]};
    endfunction

    function automatic logic strobe_of(input int k);
        case (k)
            0: return rd_n;
            1: return wr_n;
            default: return inta_n;
        endcase
    endfunction

    task automatic run_txn(input int k, input logic [19:0] a, input logic w, input logic [15:0] wd,
                           input int w0, input int w1, input logic [15:0] d0, input logic [15:0] d1,
                           input bit pre_taken, input bit hold_next, input int nk,
                           input logic [19:0] na, input logic nw, input logic [15:0] nwd);
        int phases = is_split(k, a, w) ? 2 : 1;
        if (!pre_taken) begin
            @(negedge clk);
            req_valid = 1; req_kind = 2'(k); req_addr = a; req_word = w; req_wdata = wd;
            #1 check("R12 take in idle", req_take, 1);
        end
        for (int ph = 0; ph < phases; ph++) begin
            int wt = (ph == 0) ? w0 : w1;
            logic [19:0] pa = a + 20'(ph);
            bit last = (ph == phases - 1);
            @(negedge clk);
            if (ph == 0) begin
                if (hold_next) begin
                    req_valid = 1; req_kind = 2'(nk); req_addr = na; req_word = nw; req_wdata = nwd;
                end else req_valid = 0;
            end
            #1;
            check("R3 ale in T1", ale, 1);
            check("R2 stat in T1", stat, code_of(k));
            check("R3 ad_out address in T1", ad_out, (k == 2) ? 16'h0 : pa[15:0]);
            check("R3 addr_hi in T1", addr_hi, (k == 2) ? 4'h0 : pa[19:16]);
            check("R7 bhe_n", bhe_n, exp_bhe(k, a, w, ph));
            if (hold_next) check("R12 no take in T1", req_take, 0);
            @(negedge clk); #1;
            check("R3 ale low in T2", ale, 0);
            check("R4 strobe low in T2", strobe_of(k), 0);
            check("R2 stat in T2", stat, code_of(k));
            if (k == 1) check("R5 write lane in T2", ad_out, exp_lane(a, w, ph, wd));
            if (hold_next) check("R12 no take in T2", req_take, 0);
            @(negedge clk);
            ready = (wt == 0); ad_in = (ph == 0) ? d0 : d1;
            #1;
            check("R4 strobe low in T3", strobe_of(k), 0);
            check("R2 stat in T3", stat, (wt == 0) ? 3'b111 : code_of(k));
            for (int i = 1; i <= wt; i++) begin
                @(negedge clk);
                ready = (i == wt);
                #1;
                check("R6 strobe held in Tw", strobe_of(k), 0);
                check("R2 stat in Tw", stat, (i == wt) ? 3'b111 : code_of(k));
                check("R6 done low in Tw", done, 0);
            end
            @(negedge clk); #1;
            check("R4 strobes high in T4", {rd_n, wr_n, inta_n}, 3'b111);
            check("R8 done only at last T4", done, last);
            if (k == 1) check("R5 write lane in T4", ad_out, exp_lane(a, w, ph, wd));
            if (!last) check("R2 stat in T4 before second half", stat, code_of(k));
            else if (hold_next) begin
                check("R2 stat in T4 before chained cycle", stat, code_of(nk));
                check("R12 take in final T4", req_take, 1);
            end else check("R2 stat passive in T4", stat, 3'b111);
            if (last && k != 1) check("R9 rdata", rdata, exp_rd(k, a, w, d0, d1));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        repeat (6) @(negedge clk);
        #1;
        check("R10 reset ale", ale, 0);
        check("R10 reset strobes", {rd_n, wr_n, inta_n}, 3'b111);
        check("R10 reset stat", stat, 3'b111);
        check("R10 reset done", done, 0);
        @(negedge clk); rst_n = 1;

        // Directed corner cases.
        run_txn(0, 20'hA1234, 1, 16'h0, 0, 0, 16'hBEEF, 16'h0, 0, 0, 0, 0, 0, 0);
        run_txn(1, 20'h30005, 0, 16'h00C3, 2, 0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 0);
        run_txn(0, 20'h40010, 0, 16'h0, 1, 0, 16'h5AA5, 16'h0, 0, 0, 0, 0, 0, 0);
        run_txn(0, 20'h5FFFF, 1, 16'h0, 1, 2, 16'h1234, 16'h5678, 0, 0, 0, 0, 0, 0);
        run_txn(1, 20'h60101, 1, 16'hCAFE, 0, 1, 16'h0, 16'h0, 0, 0, 0, 0, 0, 0);
        run_txn(2, 20'h7ABCD, 1, 16'h0, 3, 0, 16'h9F42, 16'h0, 0, 0, 0, 0, 0, 0);
        // R12/R1: request held during a cycle is taken only in its final T4.
        run_txn(1, 20'h12340, 1, 16'h1357, 1, 0, 16'h0, 16'h0, 0, 1, 0, 20'h22222, 1, 16'h0);
        run_txn(0, 20'h22222, 1, 16'h0, 0, 0, 16'h4321, 16'h0, 1, 0, 0, 0, 0, 0);
        @(negedge clk); #1;
        check("R1 idle after final T4", {ale, rd_n, stat}, {1'b0, 1'b1, 3'b111});

        // R11: kind code 3 is never taken.
        @(negedge clk);
        req_valid = 1; req_kind = 2'd3; req_addr = 20'h11111;
        for (int i = 0; i < 3; i++) begin
            #1;
            check("R11 kind 3 not taken", req_take, 0);
            check("R11 no ale for kind 3", ale, 0);
            @(negedge clk);
        end
        req_valid = 0;

        // Random mix.
        for (int n = 0; n < 60; n++) begin
            int k = $urandom % 3;
            logic [19:0] a = 20'($urandom);
            logic w = 1'($urandom);
            run_txn(k, a, w, 16'($urandom), $urandom % 4, $urandom % 4,
                    16'($urandom), 16'($urandom), 0, 0, 0, 0, 0, 0);
        end

        // R10: reset in the middle of a read cycle.
        @(negedge clk);
        req_valid = 1; req_kind = 2'd0; req_addr = 20'h00100; req_word = 1;
        @(negedge clk); req_valid = 0;
        @(negedge clk);
        rst_n = 0;
        repeat (4) @(negedge clk);
        #1;
        check("R10 strobes high after mid-cycle reset", {rd_n, wr_n, inta_n}, 3'b111);
        check("R10 stat passive after reset", stat, 3'b111);
        rst_n = 1;
        run_txn(0, 20'h00200, 1, 16'h0, 0, 0, 16'h7788, 16'h0, 0, 0, 0, 0, 0, 0);

        // R10: a short reset pulse leaves the block refusing requests.
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        req_valid = 1; req_kind = 2'd0; req_addr = 20'h00300; req_word = 1;
        for (int i = 0; i < 3; i++) begin
            #1;
            check("R10 no take after short reset", req_take, 0);
            check("R10 no ale after short reset", ale, 0);
            @(negedge clk);
        end
        req_valid = 0;
        rst_n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        run_txn(1, 20'h00400, 1, 16'hA5A5, 1, 0, 16'h0, 16'h0, 0, 0, 0, 0, 0, 0);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule